// File: doc/BRIEF.md
# ChaCha20 Stream Cipher Engine

This block turns a 256-bit key, a 96-bit nonce and a 32-bit starting block counter into ChaCha20 keystream. It XORs the keystream with a stream of data beats. A job begins with a one-cycle start pulse that carries the key, nonce, counter and a total byte length. The engine then builds the 16-word cipher state and runs the 20 rounds iteratively. It adds the initial state back to form a 64-byte keystream block, then takes in data through a valid/ready handshake and returns the XORed result beat by beat.

Each round takes one cycle on four parallel quarter-round units. Even cycles select the column grouping and odd cycles select the diagonal grouping. The last round cycle also performs the feed-forward addition. A block therefore costs 20 cycles before its first data beat is accepted. When the remaining length is not a multiple of the beat size, the final beat carries a contiguous byte-enable. The keystream bytes that are not used are dropped. At the end of the job the engine pulses `done` and presents the counter value of the first block that was not consumed. A job with length zero finishes at once and leaves the counter unchanged.

Top module: `chacha_engine`

## Requirements
- R1: The initial state is: words 0..3 = 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574; words 4..11 = `key[32i+31:32i]` for i = 0..7; word 12 = the block counter; words 13..15 = `nonce[32i+31:32i]` for i = 0..2.
- R2: The keystream block is the result of 10 column-then-diagonal double rounds, with each word then added modulo 2^32 to its initial value. All quarter-round arithmetic is modulo 2^32, using rotations of 16, 12, 8 and 7.
- R3: Keystream byte j of a block is bits [8(j mod 4)+7 : 8(j mod 4)] of word j/4. Data byte k of a beat is `in_data[8k+7:8k]`. Beat b of a block covers keystream bytes 16b..16b+15. Each output byte is the input byte XOR its keystream byte.
- R4: The counter word increases by exactly 1 for each 64-byte block, wrapping from 0xffffffff to 0. The nonce is the same for all blocks of a job.
- R5: On the last beat, with r < 16 bytes remaining, `out_keep` has bits 0..r-1 set and all other bits clear, and the data bytes at positions r and above are zero. All other beats have `out_keep` all ones. The rest of that keystream block is discarded.
- R6: In the cycle the last output beat first appears, `done` pulses for one cycle, `out_last` is set, and `next_ctr` equals the start counter plus ceil(length/64), modulo 2^32.
- R7: A start with length zero while idle raises `done` on the next cycle, with `next_ctr` equal to `ctr_in`. No data is exchanged.
- R8: An output beat is held stable while `out_valid` is high and `out_ready` is low. `in_ready` is low while the output register is full and not being drained, and low while rounds are running.
- R9: A start pulse while `busy` is high is ignored. The running job keeps its data, counter and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse, accepted only when idle |
| key | input | 256 | Cipher key, byte 0 in bits 7:0 |
| nonce | input | 96 | Nonce, byte 0 in bits 7:0 |
| ctr_in | input | 32 | Counter for the first block |
| len_in | input | LEN_W | Job length in bytes |
| busy | output | 1 | A job is in progress |
| in_valid | input | 1 | Input data beat valid |
| in_ready | output | 1 | Engine accepts an input beat |
| in_data | input | DATA_W | Input data beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | XORed output beat, disabled bytes zero |
| out_keep | output | DATA_W/8 | Byte enable of the output beat |
| out_last | output | 1 | Final beat of the job |
| done | output | 1 | One-cycle job completion pulse |
| next_ctr | output | 32 | Counter of the first unused block |

## Verification
The bench builds the engine with its default parameters: 128-bit beats (four beats per block), a 16-bit length field and ten double rounds. These are the values the cipher requires, so the output can be compared both against a known published keystream block and against an independent reference model in the bench. The 16-bit length covers multi-block jobs. With the chosen lengths, the partial-beat masks include the one-byte and five-byte cases, a job ends exactly on a block boundary, and a counter that starts at 0xffffffff wraps into the second block.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

  localparam int WORD_W = 32;
  localparam int N_WORDS = 16;
  localparam int BLK_W = WORD_W * N_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // Initial state: fixed words, key, counter, nonce
  function automatic state_t mk_state(input logic [255:0] k,
                                      input logic [95:0] n,
                                      input word_t c);
    state_t s;
    s[0] = 32'h61707865;
    s[1] = 32'h3320646e;
    s[2] = 32'h79622d32;
    s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = c;
    for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
    return s;
  endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, b2, d2;

  always_comb begin
    a1  = a_i + b_i;
    d1  = rotl(d_i ^ a1, 16);
    c1  = c_i + d1;
    b1  = rotl(b_i ^ c1, 12);
    a_o = a1 + b1;
    d2  = rotl(d1 ^ a_o, 8);
    c_o = c1 + d2;
    b2  = rotl(b1 ^ c_o, 7);
    b_o = b2;
    d_o = d2;
  end
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  state_t st_i,
  input  logic   diag,
  output state_t st_o
);
  word_t qa [4];
  word_t qb [4];
  word_t qc [4];
  word_t qd [4];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    localparam int IB_COL = 4 + k;
    localparam int IC_COL = 8 + k;
    localparam int ID_COL = 12 + k;
    localparam int IB_DIA = 4 + ((k + 1) % 4);
    localparam int IC_DIA = 8 + ((k + 2) % 4);
    localparam int ID_DIA = 12 + ((k + 3) % 4);

    chacha_qr u_qr (
      .a_i(st_i[k]),
      .b_i(diag ? st_i[IB_DIA] : st_i[IB_COL]),
      .c_i(diag ? st_i[IC_DIA] : st_i[IC_COL]),
      .d_i(diag ? st_i[ID_DIA] : st_i[ID_COL]),
      .a_o(qa[k]),
      .b_o(qb[k]),
      .c_o(qc[k]),
      .d_o(qd[k])
    );
  end

  always_comb begin
    st_o = '0;
    for (int k = 0; k < 4; k++) begin
      st_o[k] = qa[k];
      if (diag) begin
        st_o[4 + ((k + 1) % 4)]  = qb[k];
        st_o[8 + ((k + 2) % 4)]  = qc[k];
        st_o[12 + ((k + 3) % 4)] = qd[k];
      end else begin
        st_o[4 + k]  = qb[k];
        st_o[8 + k]  = qc[k];
        st_o[12 + k] = qd[k];
      end
    end
  end
endmodule

// File: rtl/chacha_engine.sv
module chacha_engine
  import chacha_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int LEN_W   = 16,
  parameter int DROUNDS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [255:0]      key,
  input  logic [95:0]       nonce,
  input  logic [31:0]       ctr_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic              busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W/8-1:0] out_keep,
  output logic              out_last,
  output logic              done,
  output logic [31:0]       next_ctr
);
  localparam int BB     = DATA_W / 8;
  localparam int BEATS  = BLK_W / DATA_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int NR     = 2 * DROUNDS;
  localparam int RND_W  = $clog2(NR);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_XOR} phase_t;

  phase_t             phase;
  logic [255:0]       key_r;
  logic [95:0]        nonce_r;
  word_t              ctr_r;
  logic [LEN_W-1:0]   rem_r;
  state_t             st_r;
  state_t             st_nx;
  state_t             init_s;
  state_t             ff_s;
  logic [BLK_W-1:0]   ks_r;
  logic [RND_W-1:0]   rnd_r;
  logic [BEAT_W-1:0]  beat_r;
  logic [DATA_W-1:0]  ks_beat;
  logic [DATA_W-1:0]  xor_c;
  logic [BB-1:0]      keep_c;
  logic               accept, final_beat, blk_end;

  chacha_round u_round (
    .st_i(st_r),
    .diag(rnd_r[0]),
    .st_o(st_nx)
  );

  always_comb begin
    init_s = mk_state(key_r, nonce_r, ctr_r);
    for (int i = 0; i < N_WORDS; i++) ff_s[i] = st_nx[i] + init_s[i];
  end

  assign ks_beat    = ks_r[beat_r*DATA_W +: DATA_W];
  assign busy       = (phase != S_IDLE);
  assign in_ready   = (phase == S_XOR) && (!out_valid || out_ready);
  assign accept     = in_valid && in_ready;
  assign final_beat = (rem_r <= LEN_W'(BB));
  assign blk_end    = final_beat || (beat_r == BEAT_W'(BEATS - 1));

  always_comb begin
    for (int i = 0; i < BB; i++) begin
      keep_c[i]        = (rem_r > LEN_W'(i));
      xor_c[8*i +: 8]  = keep_c[i] ? (in_data[8*i +: 8] ^ ks_beat[8*i +: 8]) : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= S_IDLE;
      key_r     <= '0;
      nonce_r   <= '0;
      ctr_r     <= '0;
      rem_r     <= '0;
      st_r      <= '0;
      ks_r      <= '0;
      rnd_r     <= '0;
      beat_r    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_keep  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      next_ctr  <= '0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (phase)
        S_IDLE: begin
          if (start) begin
            if (len_in == '0) begin
              done     <= 1'b1;
              next_ctr <= ctr_in;
            end else begin
              key_r   <= key;
              nonce_r <= nonce;
              ctr_r   <= ctr_in;
              rem_r   <= len_in;
              st_r    <= mk_state(key, nonce, ctr_in);
              rnd_r   <= '0;
              phase   <= S_RUN;
            end
          end
        end
        S_RUN: begin
          st_r <= st_nx;
          if (rnd_r == RND_W'(NR - 1)) begin
            ks_r   <= ff_s;
            beat_r <= '0;
            phase  <= S_XOR;
          end else begin
            rnd_r <= rnd_r + 1'b1;
          end
        end
        S_XOR: begin
          if (accept) begin
            out_valid <= 1'b1;
            out_data  <= xor_c;
            out_keep  <= keep_c;
            out_last  <= final_beat;
            rem_r     <= rem_r - LEN_W'(BB);
            beat_r    <= beat_r + 1'b1;
            if (final_beat) begin
              done     <= 1'b1;
              next_ctr <= ctr_r + 32'd1;
              phase    <= S_IDLE;
            end else if (blk_end) begin
              ctr_r <= ctr_r + 32'd1;
              st_r  <= mk_state(key_r, nonce_r, ctr_r + 32'd1);
              rnd_r <= '0;
              phase <= S_RUN;
            end
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chacha_engine_chk.sv
module chacha_engine_chk #(
  parameter int DATA_W = 128,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [31:0]       ctr_in,
  input logic [LEN_W-1:0]  len_in,
  input logic              busy,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W/8-1:0] out_keep,
  input logic              done,
  input logic [31:0]       next_ctr
);
  localparam int BB = DATA_W / 8;
  localparam logic [BB-1:0] ONE = BB'(1);

  // R5: the byte enable is a non-empty run of ones starting at bit 0
  p_keep_contig_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_keep & (out_keep + ONE)) == '0) && (out_keep != '0)));

  // R8: a stalled output beat does not change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_keep)));

  // R8: no input is taken while the output is blocked or no job runs
  p_inready_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (busy && (!out_valid || out_ready)));

  // R6: completion coincides with the engine going idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: an empty job finishes on the next cycle with the counter unchanged
  p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (len_in == '0)) |=> (done && (next_ctr == $past(ctr_in))));
endmodule

bind chacha_engine chacha_engine_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ctr_in(ctr_in), .len_in(len_in),
  .busy(busy), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_keep(out_keep), .done(done), .next_ctr(next_ctr)
);

// File: tb/chacha_engine_tb.sv
`timescale 1ns/1ps
module chacha_engine_tb;
  localparam int DATA_W = 128;
  localparam int LEN_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [255:0] key = '0;
  logic [95:0] nonce = '0;
  logic [31:0] ctr_in = '0;
  logic [LEN_W-1:0] len_in = '0;
  logic busy, in_ready, out_valid, out_last, done;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic [DATA_W-1:0] out_data;
  logic [15:0] out_keep;
  logic [31:0] next_ctr;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  chacha_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DROUNDS(10)) u_dut (
    .clk(clk), .rst(rst), .start(start), .key(key), .nonce(nonce),
    .ctr_in(ctr_in), .len_in(len_in), .busy(busy), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
    .out_last(out_last), .done(done), .next_ctr(next_ctr)
  );

  // {counter, length, seed}
  localparam logic [55:0] VEC [6] = '{
    {32'h00000000, 16'd64,  8'h01},
    {32'h00000007, 16'd100, 8'h02},
    {32'hffffffff, 16'd80,  8'h03},
    {32'h00000003, 16'd5,   8'h04},
    {32'h0000000a, 16'd128, 8'h05},
    {32'h00000014, 16'd17,  8'h06}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_qr(input logic [31:0] a, b, c, d);
    a = a + b; d = d ^ a; d = {d[15:0], d[31:16]};
    c = c + d; b = b ^ c; b = {b[19:0], b[31:20]};
    a = a + b; d = d ^ a; d = {d[23:0], d[31:24]};
    c = c + d; b = b ^ c; b = {b[24:0], b[31:25]};
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] ref_block(input logic [255:0] k, input logic [95:0] n,
                                             input logic [31:0] c);
    logic [31:0] x [16];
    logic [31:0] s0 [16];
    logic [127:0] q;
    logic [511:0] r;
    x[0] = 32'h61707865; x[1] = 32'h3320646e; x[2] = 32'h79622d32; x[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) x[4+i] = k[32*i +: 32];
    x[12] = c;
    for (int i = 0; i < 3; i++) x[13+i] = n[32*i +: 32];
    for (int i = 0; i < 16; i++) s0[i] = x[i];
    for (int it = 0; it < 10; it++)
      for (int p = 0; p < 2; p++)
        for (int j = 0; j < 4; j++) begin
          int ib, ic, id;
          ib = 4 + (j + p) % 4; ic = 8 + (j + 2*p) % 4; id = 12 + (j + 3*p) % 4;
          q = ref_qr(x[j], x[ib], x[ic], x[id]);
          x[j] = q[127:96]; x[ib] = q[95:64]; x[ic] = q[63:32]; x[id] = q[31:0];
        end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s0[i];
    return r;
  endfunction

  function automatic logic [255:0] mk_key(input logic [7:0] sd);
    logic [255:0] k;
    for (int i = 0; i < 32; i++) k[8*i +: 8] = sd * 8'd31 + 8'(i * 5);
    return k;
  endfunction

  function automatic logic [95:0] mk_nonce(input logic [7:0] sd);
    logic [95:0] n;
    for (int i = 0; i < 12; i++) n[8*i +: 8] = sd * 8'd11 + 8'(i * 3 + 1);
    return n;
  endfunction

  function automatic logic [127:0] mk_data(input logic [7:0] sd, input int off);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[8*b +: 8] = sd * 8'd7 + 8'((off + b) * 13);
    return d;
  endfunction

  // Expected output and keep for the beat at byte offset off
  task automatic expect_beat(input logic [255:0] k, input logic [95:0] n, input logic [31:0] c,
                             input int len, input int off, input logic [127:0] din,
                             output logic [127:0] exp_d, output logic [15:0] exp_k);
    logic [511:0] blk;
    int bi;
    blk = ref_block(k, n, c + 32'(off / 64));
    bi  = (off % 64) / 16;
    exp_d = '0; exp_k = '0;
    for (int b = 0; b < 16; b++)
      if (off + b < len) begin
        exp_k[b] = 1'b1;
        exp_d[8*b +: 8] = din[8*b +: 8] ^ blk[(bi*16 + b)*8 +: 8];
      end
  endtask

  task automatic run_job(input logic [255:0] k, input logic [95:0] n, input logic [31:0] c,
                         input int len, input logic [7:0] sd, input bit poke);
    logic [127:0] din, exp_d;
    logic [15:0] exp_k;
    logic [31:0] exp_ctr;
    bit last;
    exp_ctr = c + 32'((len + 63) / 64);
    @(negedge clk);
    key = k; nonce = n; ctr_in = c; len_in = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start = 1'b1; len_in = '0; ctr_in = c ^ 32'h55;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R9", 128'(done), 128'd0);
    end
    for (int off = 0; off < len; off += 16) begin
      din  = mk_data(sd, off);
      last = (off + 16 >= len);
      expect_beat(k, n, c, len, off, din, exp_d, exp_k);
      in_valid = 1'b1; in_data = din;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R8", 128'(out_valid), 128'd1);
      // R3 data ordering / R4 counter per block / R5 masked tail
      check(out_data == exp_d, (exp_k != 16'hffff) ? "R5" : "R3", out_data, exp_d);
      check(out_keep == exp_k, "R5", 128'(out_keep), 128'(exp_k));
      check(done == last && out_last == last, "R6", 128'({done, out_last}), 128'({last, last}));
      if (last) check(next_ctr == exp_ctr, "R6", 128'(next_ctr), 128'(exp_ctr));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] k;
    logic [95:0] n;
    logic [127:0] exp0, exp1, d0, d1;
    logic [15:0] ek;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check({busy, in_ready, out_valid, done} == 4'b0, "R8",
          128'({busy, in_ready, out_valid, done}), 128'd0);

    // R1 R2: published block, key bytes 0..31, counter 1, zero data
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    n = {32'h00000000, 32'h4a000000, 32'h09000000};
    @(negedge clk);
    key = k; nonce = n; ctr_in = 32'd1; len_in = 16'd16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1; in_data = '0;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data == 128'hc47120a3_1fdd0f50_15593bd1_e4e7f110, "R1", out_data,
          128'hc47120a3_1fdd0f50_15593bd1_e4e7f110);
    check(out_data == ref_block(k, n, 32'd1)[127:0], "R2", out_data, ref_block(k, n, 32'd1)[127:0]);
    check(next_ctr == 32'd2, "R6", 128'(next_ctr), 128'd2);

    // Vector table: counter wrap (R4), tails (R5), boundaries (R6)
    for (int v = 0; v < 6; v++)
      run_job(mk_key(VEC[v][7:0]), mk_nonce(VEC[v][7:0]), VEC[v][55:24],
              int'(VEC[v][23:8]), VEC[v][7:0], 1'b0);

    // R9: start while busy has no effect
    run_job(mk_key(8'h21), mk_nonce(8'h21), 32'h00000100, 72, 8'h21, 1'b1);

    // R7: empty job
    @(negedge clk);
    ctr_in = 32'h12345678; len_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && next_ctr == 32'h12345678, "R7", 128'({done, next_ctr}),
          128'({1'b1, 32'h12345678}));
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R7", 128'({busy, out_valid}), 128'd0);

    // R8: back-pressure on the output
    k = mk_key(8'h33); n = mk_nonce(8'h33);
    d0 = mk_data(8'h33, 0); d1 = mk_data(8'h33, 16);
    expect_beat(k, n, 32'd40, 32, 0, d0, exp0, ek);
    expect_beat(k, n, 32'd40, 32, 16, d1, exp1, ek);
    key = k; nonce = n; ctr_in = 32'd40; len_in = 16'd32; start = 1'b1;
    @(negedge clk);
    start = 1'b0; out_ready = 1'b0;
    in_valid = 1'b1; in_data = d0;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_data = d1;
    check(out_valid && out_data == exp0, "R8", out_data, exp0);
    check(in_ready == 1'b0, "R8", 128'(in_ready), 128'd0);
    repeat (3) @(negedge clk);
    check(out_valid && out_data == exp0 && !in_ready, "R8", out_data, exp0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data == exp1 && done, "R8", out_data, exp1);
    check(next_ctr == 32'd41, "R6", 128'(next_ctr), 128'd41);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule